// File: doc/BRIEF.md
# Windowed Watchdog Timer

This block is a windowed watchdog with a small synchronous register interface. A 7-bit down-counter steps once per divided tick. The tick period is a base divide (TICK_DIV bus-clock cycles) times a selectable factor of 1, 2, 4 or 8. Once the watchdog is activated, software must reload the counter while its value is at or below a programmed window value, and before bit 6 of the counter drops to zero. A reload that comes too early raises a reset request. A reload with bit 6 clear also raises one, and so does letting the counter fall from 0x40 to 0x3F.

An early-warning flag sets one tick before the timeout point. When it is enabled, it drives an interrupt output. The reset request is a one-cycle pulse. In the same edge that raises it, the block returns to its power-on state. The system reset controller that acts on the pulse is outside this block.

Writes use `bus_wr`, `bus_addr` and `bus_wdata` and take effect at the clock edge. Reads use a separate address, `rd_addr`, and `rd_data` is combinational. There are three registers:

- Address 0 (control): bits [6:0] hold the counter and bit 7 is the activation bit. A write reloads the counter.
- Address 1 (config): bits [6:0] hold the window value, bits [8:7] hold the prescaler select, and bit 9 enables the interrupt.
- Address 2 (status): bit 0 is the early-warning flag.

Top module: `win_watchdog`

## Requirements
- R1: After reset, the control register reads 0x07F (counter 0x7F, inactive). The config register reads 0x07F (window 0x7F, select 0, interrupt disabled). Status reads 0, address 3 reads 0, and `irq_warn` and `rst_req` are low.
- R2: The counter decrements by one, modulo 128, once every TICK_DIV×2^sel cycles. Here sel is config bits [8:7], and the tick fires when the divider reaches or exceeds the period minus one. A control write loads the counter from bits [6:0] and restarts the divider, so the first decrement comes a full period later. A control write takes priority over a tick in the same cycle.
- R3: While active, a tick at counter value 0x40 that is not overridden by a control write produces a reset request.
- R4: While active, a control write with data bit 6 equal to 0 produces a reset request.
- R5: While active, a control write when the counter is greater than the window value produces a reset request. A write with the counter equal to or below the window, and with bit 6 set, is accepted as a reload.
- R6: A control write with bit 7 set makes the block active, and only a reset request or system reset clears that state. While inactive, the counter still counts and wraps, and no reset request is ever produced.
- R7: The status flag sets on the tick that moves the counter from 0x41 to 0x40. Writing status with bit 0 = 0 clears it, and writing bit 0 = 1 has no effect. If set and clear occur in the same cycle, the set wins. `irq_warn` equals the flag ANDed with config bit 9.
- R8: `rst_req` is high for exactly one cycle, the cycle after the fault. In that cycle all registers already hold their R1 values.
- R9: The read map is: address 0 gives {active, counter}; address 1 gives {irq enable, select, window}; address 2 gives the flag in bit 0; address 3 gives 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 2 | Write register address |
| bus_wdata | input | 10 | Write data |
| rd_addr | input | 2 | Read register address |
| rd_data | output | 10 | Read data for `rd_addr` |
| irq_warn | output | 1 | Early-warning interrupt |
| rst_req | output | 1 | One-cycle reset request |

## Verification
The assertions check the following on every cycle:
- The reset request lasts a single cycle, and the block is already in its power-on state when the request is high.
- The activation bit stays set once it is set.
- The counter only ever steps down by one unless a reload intervenes.
- The warning flag rises only on the 0x41 to 0x40 step.
- Each of the three fault causes (timeout, bit 6 clear, reload above the window) is followed by a request.

Only the bench scenarios can show the tick period for each prescaler select, and that the divider restarts after a reload. The same holds for the exact window boundary where the counter equals the window value, the counter wrapping while inactive, and the flag ignoring a write of 1.

// File: rtl/win_watchdog.sv
module win_watchdog #(
  parameter int TICK_DIV = 4096
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_wr,
  input  logic [1:0] bus_addr,
  input  logic [9:0] bus_wdata,
  input  logic [1:0] rd_addr,
  output logic [9:0] rd_data,
  output logic       irq_warn,
  output logic       rst_req
);
  localparam int DIV_W = $clog2(TICK_DIV * 8);
  localparam logic [6:0] CNT_INIT = 7'h7F;
  localparam logic [6:0] CNT_EDGE = 7'h40;
  localparam logic [6:0] CNT_WARN = 7'h41;

  logic [DIV_W-1:0] div_q;
  logic [DIV_W:0]   div_lim;
  logic [6:0]       cnt_q, win_q;
  logic [1:0]       sel_q;
  logic             ie_q, flag_q, act_q, rst_q;
  logic             tick, ctrl_wr, cfg_wr, st_wr, fault, warn_set;

  assign ctrl_wr  = bus_wr && bus_addr == 2'd0;
  assign cfg_wr   = bus_wr && bus_addr == 2'd1;
  assign st_wr    = bus_wr && bus_addr == 2'd2;
  assign div_lim  = ((DIV_W+1)'(TICK_DIV) << sel_q) - (DIV_W+1)'(1);
  assign tick     = {1'b0, div_q} >= div_lim;
  assign warn_set = !ctrl_wr && tick && cnt_q == CNT_WARN;
  assign fault    = act_q && (ctrl_wr ? (!bus_wdata[6] || cnt_q > win_q)
                                      : (tick && cnt_q == CNT_EDGE));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q  <= '0;
      cnt_q  <= CNT_INIT;
      win_q  <= CNT_INIT;
      sel_q  <= 2'd0;
      ie_q   <= 1'b0;
      flag_q <= 1'b0;
      act_q  <= 1'b0;
      rst_q  <= 1'b0;
    end else if (fault) begin
      div_q  <= '0;
      cnt_q  <= CNT_INIT;
      win_q  <= CNT_INIT;
      sel_q  <= 2'd0;
      ie_q   <= 1'b0;
      flag_q <= 1'b0;
      act_q  <= 1'b0;
      rst_q  <= 1'b1;
    end else begin
      rst_q <= 1'b0;
      if (ctrl_wr) begin
        cnt_q <= bus_wdata[6:0];
        act_q <= act_q | bus_wdata[7];
        div_q <= '0;
      end else if (tick) begin
        cnt_q <= cnt_q - 7'd1;
        div_q <= '0;
      end else begin
        div_q <= div_q + DIV_W'(1);
      end
      if (cfg_wr) begin
        win_q <= bus_wdata[6:0];
        sel_q <= bus_wdata[8:7];
        ie_q  <= bus_wdata[9];
      end
      if (warn_set)
        flag_q <= 1'b1;
      else if (st_wr && !bus_wdata[0])
        flag_q <= 1'b0;
    end
  end

  always_comb begin
    case (rd_addr)
      2'd0:    rd_data = {2'b00, act_q, cnt_q};
      2'd1:    rd_data = {ie_q, sel_q, win_q};
      2'd2:    rd_data = {9'd0, flag_q};
      default: rd_data = '0;
    endcase
  end

  assign irq_warn = flag_q & ie_q;
  assign rst_req  = rst_q;
endmodule

// File: rtl/win_watchdog_chk.sv
module win_watchdog_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ctrl_wr,
  input logic       wbit6,
  input logic       tick,
  input logic       act,
  input logic [6:0] cnt,
  input logic [6:0] win,
  input logic       flag,
  input logic       rst_req
);
  // R8
  rst_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> !rst_req);
  // R8
  rst_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> (!act && cnt == 7'h7F && win == 7'h7F && !flag));
  // R6
  act_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(act) && !rst_req |-> act);
  // R6
  inactive_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !act |=> !rst_req);
  // R2
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt != $past(cnt) && !$past(ctrl_wr) && !rst_req |-> cnt == $past(cnt) - 7'd1);
  // R7
  flag_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> ($past(cnt) == 7'h41 && cnt == 7'h40));
  // R3
  timeout_chk: assert property (@(posedge clk) disable iff (!rst_n)
    act && !ctrl_wr && tick && cnt == 7'h40 |=> rst_req);
  // R4
  bit6_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    act && ctrl_wr && !wbit6 |=> rst_req);
  // R5
  early_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    act && ctrl_wr && cnt > win |=> rst_req);
endmodule

bind win_watchdog win_watchdog_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr), .wbit6(bus_wdata[6]),
  .tick(tick), .act(act_q), .cnt(cnt_q), .win(win_q), .flag(flag_q),
  .rst_req(rst_req)
);

// File: tb/tb_win_watchdog.sv
module tb_win_watchdog;
  localparam int CLK_PERIOD = 10;
  localparam int TD = 4;
  localparam int WD_LIMIT = 150000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_wr = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic [9:0] bus_wdata = 10'd0;
  logic [1:0] rd_addr = 2'd0;
  wire  [9:0] rd_data;
  wire        irq_warn, rst_req;

  win_watchdog #(.TICK_DIV(TD)) dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .rd_addr(rd_addr), .rd_data(rd_data),
    .irq_warn(irq_warn), .rst_req(rst_req)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int         m_div;
  logic [6:0] m_cnt, m_win;
  logic [1:0] m_sel;
  bit         m_ie, m_flag, m_act, m_rst;
  int         checks = 0, fails = 0, cycles = 0;
  string      tag = "R1";

  task automatic model_reset();
    m_div = 0; m_cnt = 7'h7F; m_win = 7'h7F; m_sel = 2'd0;
    m_ie = 0; m_flag = 0; m_act = 0; m_rst = 0;
  endtask

  function automatic logic [9:0] exp_rd(input logic [1:0] a);
    case (a)
      2'd0:    return {2'b00, m_act, m_cnt};
      2'd1:    return {m_ie, m_sel, m_win};
      2'd2:    return {9'd0, m_flag};
      default: return 10'd0;
    endcase
  endfunction

  task automatic model_step(input bit wr, input logic [1:0] a, input logic [9:0] d);
    int lim;
    bit tk, cw, flt, st;
    lim = (TD << m_sel) - 1;
    tk  = m_div >= lim;
    cw  = wr && a == 2'd0;
    flt = m_act && (cw ? (!d[6] || m_cnt > m_win) : (tk && m_cnt == 7'h40));
    if (flt) begin
      model_reset();
      m_rst = 1;
      return;
    end
    m_rst = 0;
    st = !cw && tk && m_cnt == 7'h41;
    if (cw) begin
      m_cnt = d[6:0]; m_act = m_act | d[7]; m_div = 0;
    end else if (tk) begin
      m_cnt = m_cnt - 7'd1; m_div = 0;
    end else begin
      m_div = m_div + 1;
    end
    if (wr && a == 2'd1) begin
      m_win = d[6:0]; m_sel = d[8:7]; m_ie = d[9];
    end
    if (st) m_flag = 1;
    else if (wr && a == 2'd2 && !d[0]) m_flag = 0;
  endtask

  task automatic check(input string what, input logic [9:0] act, input logic [9:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  task automatic cyc(input bit wr, input logic [1:0] a, input logic [9:0] d, input logic [1:0] ra);
    @(negedge clk);
    bus_wr = wr; bus_addr = a; bus_wdata = d; rd_addr = ra;
    #1;
    check("rd_data", rd_data, exp_rd(ra));
    check("rst_req", {9'd0, rst_req}, {9'd0, m_rst});
    check("irq_warn", {9'd0, irq_warn}, {9'd0, m_flag & m_ie});
    model_step(wr, a, d);
    cycles++;
    if (cycles > WD_LIMIT) begin
      fails++;
      $display("FAIL watchdog expired actual=%0d expected<=%0d", cycles, WD_LIMIT);
      finish_run();
    end
  endtask

  task automatic idle(input int n, input logic [1:0] ra);
    for (int i = 0; i < n; i++) cyc(0, 2'd0, 10'd0, ra);
  endtask

  initial begin
    int unsigned seed;
    seed = 32'd20241;
    void'($urandom(seed));
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    tag = "R1";
    for (int a = 0; a < 4; a++) cyc(0, 2'd0, 10'd0, 2'(a));

    tag = "R2";
    cyc(1, 2'd1, 10'h0FF, 2'd1);
    cyc(1, 2'd0, 10'h07F, 2'd0);
    idle(45, 2'd0);
    cyc(1, 2'd0, 10'h050, 2'd0);
    idle(20, 2'd0);

    tag = "R7";
    cyc(1, 2'd2, 10'h000, 2'd2);
    cyc(1, 2'd1, 10'h27F, 2'd2);
    cyc(1, 2'd0, 10'h045, 2'd2);
    idle(25, 2'd2);
    cyc(1, 2'd2, 10'h001, 2'd2);
    idle(2, 2'd2);
    cyc(1, 2'd2, 10'h000, 2'd2);
    idle(2, 2'd2);

    tag = "R6";
    cyc(1, 2'd0, 10'h07F, 2'd0);
    idle(600, 2'd0);

    tag = "R3";
    cyc(1, 2'd1, 10'h27F, 2'd2);
    cyc(1, 2'd0, 10'h0FF, 2'd0);
    idle(280, 2'd0);

    tag = "R4";
    cyc(1, 2'd0, 10'h0FF, 2'd0);
    idle(3, 2'd0);
    cyc(1, 2'd0, 10'h0B0, 2'd0);
    idle(3, 2'd1);

    tag = "R5";
    cyc(1, 2'd1, 10'h050, 2'd1);
    cyc(1, 2'd0, 10'h0FF, 2'd0);
    idle(5, 2'd0);
    cyc(1, 2'd0, 10'h0FF, 2'd0);
    idle(2, 2'd1);
    cyc(1, 2'd1, 10'h050, 2'd1);
    cyc(1, 2'd0, 10'h0FF, 2'd0);
    while (m_cnt > 7'h50) cyc(0, 2'd0, 10'd0, 2'd0);
    cyc(1, 2'd0, 10'h0FF, 2'd0);
    idle(3, 2'd0);

    tag = "R8";
    cyc(1, 2'd0, 10'h0FF, 2'd0);
    cyc(1, 2'd0, 10'h0FF, 2'd1);
    idle(3, 2'd0);

    tag = "R9";
    for (int i = 0; i < 4000; i++) begin
      int unsigned r;
      logic [9:0] d;
      r = $urandom % 100;
      d = 10'($urandom);
      if (r < 3) begin
        if ($urandom % 5 != 0) d[6] = 1'b1;
        cyc(1, 2'd0, d, 2'($urandom));
      end else if (r < 6) begin
        d[6] = 1'b1;
        cyc(1, 2'd1, d, 2'($urandom));
      end else if (r < 8) begin
        cyc(1, 2'd2, d, 2'($urandom));
      end else begin
        cyc(0, 2'($urandom), d, 2'($urandom));
      end
    end
    finish_run();
  end
endmodule